// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block sits next to a small 8-bit processor core. It collects five interrupt request lines and picks one winner each cycle. The lines are a non-maskable trap, three maskable restart lines named 7.5, 6.5 and 5.5, and one general external request. The block presents the winner as a request with a 16-bit vector address. The trap cannot be blocked by anything. The three restart lines are gated by a software mask register and by a global interrupt enable. The external request is gated by the global enable only.

Software programs the block with a mask write and inspects it through a status byte. The mask write can change the three mask bits and can discard a latched 7.5 edge. The status byte reports the masks, the global enable and the raw pending state of the restart lines. The processor tells the block that it is taking the presented request by pulsing an accept input. The block then returns a one-cycle acknowledge to the source that was serviced. The general request line has no internal vector, so when it wins the block raises a flag meaning the vector must come from outside.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, `stat_rdata` reads 0x07 (all three masks set, enable clear, nothing pending), `req_valid` is 0 and `src_ack` is 0.
- R2: The trap is accepted only when `trap_in` is seen low, then high, then still high on the following clock. Once accepted it is requested with vector 0x0024 whatever the masks and the enable are. It stays latched until it is serviced. Servicing it leaves the enable unchanged, and a trap level held high afterwards is not accepted again.
- R3: A rising edge on `r75_in` sets the 7.5 pending flag (status bit 6) one clock later, even while 7.5 is masked or the enable is clear. The flag is cleared when 7.5 is serviced, or by a mask write with bit 4 set; that mask write leaves the masks alone when bit 3 is 0.
- R4: Lines 6.5 and 5.5 are level sensitive. Status bits 5 and 4 show the level of `r65_in` and `r55_in` one clock after it is applied.
- R5: A mask write stores bits 2:0 (bit 2 masks 7.5, bit 1 masks 6.5, bit 0 masks 5.5; 1 blocks) only when bit 3 of the written value is 1. Otherwise the masks keep their value.
- R6: The status byte holds the masks in bits 2:0, the global enable in bit 3, the pending flags for 5.5, 6.5 and 7.5 in bits 4, 5 and 6, and 0 in bit 7.
- R7: Among eligible sources, priority runs trap, 7.5, 6.5, 5.5, external request. The vectors are 0x0024, 0x003C, 0x0034 and 0x002C for trap, 7.5, 6.5 and 5.5.
- R8: When the external request wins, `req_ext` is 1 and `req_vec` is 0x0000. The external request is blocked by the global enable but not by the mask bits.
- R9: `ack_in` high while `req_valid` is high gives a one-hot `src_ack` on the next clock that lasts one cycle. The bits are: bit 0 trap, bit 1 7.5, bit 2 6.5, bit 3 5.5, bit 4 external.
- R10: `ie_set` sets the global enable and `ie_clr` clears it. Servicing any source other than the trap clears the enable, and this clearing wins over a simultaneous `ie_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_in | input | 1 | Non-maskable trap request |
| r75_in | input | 1 | Edge-triggered restart 7.5 request |
| r65_in | input | 1 | Level restart 6.5 request |
| r55_in | input | 1 | Level restart 5.5 request |
| ext_in | input | 1 | General external request |
| ie_set | input | 1 | Enable-interrupts command |
| ie_clr | input | 1 | Disable-interrupts command |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 5 | Mask write value: [2:0] masks, [3] mask enable, [4] clear 7.5 |
| stat_rdata | output | 8 | Status byte |
| ack_in | input | 1 | Processor accepts the presented request |
| req_valid | output | 1 | A request is presented |
| req_vec | output | 16 | Vector address of the winner |
| req_ext | output | 1 | Winner needs an externally supplied vector |
| src_ack | output | 5 | One-cycle acknowledge to the serviced source |

## Verification
Several lines are raised at once with the enable set, and the winner and its vector show that the priority order is right. The lines are then dropped or serviced one at a time, so that each lower source wins in turn. Trap stimulus comes in two forms, a single-cycle blip and a held level, and only the held level is accepted. A 7.5 pulse given while masked and disabled shows that the edge is latched, and a later mask write shows that the latch can be cleared. Mask writes with and without the mask-enable bit show when new mask values are stored. Servicing each source checks the acknowledge bit, the clearing of the enable, and the fact that a trap leaves the enable unchanged.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC  = 5;
    localparam int VEC_W = 16;
    localparam int NLVL  = 2;

    typedef enum logic [2:0] {
        SRC_TRAP = 3'd0,
        SRC_R75  = 3'd1,
        SRC_R65  = 3'd2,
        SRC_R55  = 3'd3,
        SRC_EXT  = 3'd4
    } src_e;

    // mask write value as seen on the bus
    typedef struct packed {
        logic       clr75;
        logic       mask_en;
        logic [2:0] mask;
    } setm_t;

    // status byte layout
    typedef struct packed {
        logic       zero;
        logic [2:0] pend;
        logic       ie;
        logic [2:0] mask;
    } stat_t;

    function automatic logic [VEC_W-1:0] vec_of(input int idx);
        logic [VEC_W-1:0] v;
        case (idx)
            int'(SRC_TRAP): v = VEC_W'(16'h0024);
            int'(SRC_R75):  v = VEC_W'(16'h003C);
            int'(SRC_R65):  v = VEC_W'(16'h0034);
            int'(SRC_R55):  v = VEC_W'(16'h002C);
            default:        v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [NSRC-1:0] pick_first(input logic [NSRC-1:0] v);
        logic [NSRC-1:0] r;
        logic            found;
        r     = '0;
        found = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (v[i] && !found) begin
                r[i]  = 1'b1;
                found = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_capture.sv
module irqc_capture
    import irqc_pkg::*;
#(
    parameter int N_LVL = NLVL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_in,
    input  logic             r75_in,
    input  logic [N_LVL-1:0] lvl_in,
    input  logic             trap_take,
    input  logic             r75_take,
    input  logic             r75_sw_clr,
    output logic             trap_pend,
    output logic             r75_pend,
    output logic [N_LVL-1:0] lvl_pend
);

    logic trap_prev, trap_armed, r75_prev;

    // trap: rising edge arms, still high one clock later accepts
    always_ff @(posedge clk) begin
        if (rst) begin
            trap_prev  <= 1'b0;
            trap_armed <= 1'b0;
            trap_pend  <= 1'b0;
        end else begin
            trap_prev <= trap_in;
            if (trap_in && !trap_prev)
                trap_armed <= 1'b1;
            else if (!trap_in || trap_armed)
                trap_armed <= 1'b0;
            if (trap_take)
                trap_pend <= 1'b0;
            else if (trap_armed && trap_in)
                trap_pend <= 1'b1;
        end
    end

    // restart 7.5: edge latch
    always_ff @(posedge clk) begin
        if (rst) begin
            r75_prev <= 1'b0;
            r75_pend <= 1'b0;
        end else begin
            r75_prev <= r75_in;
            if (r75_take || r75_sw_clr)
                r75_pend <= 1'b0;
            else if (r75_in && !r75_prev)
                r75_pend <= 1'b1;
        end
    end

    // level-sensitive restarts, one register each
    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) lvl_pend[g] <= 1'b0;
            else     lvl_pend[g] <= lvl_in[g];
        end
    end

endmodule

// File: rtl/irqc_maskreg.sv
module irqc_maskreg
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  setm_t      wdata,
    input  logic       ie_set,
    input  logic       ie_clr,
    input  logic       take_gated,
    output logic [2:0] mask,
    output logic       ie,
    output logic       clr75
);

    assign clr75 = wr && wdata.clr75;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= 3'b111;
            ie   <= 1'b0;
        end else begin
            if (wr && wdata.mask_en)
                mask <= wdata.mask;
            if (take_gated || ie_clr)
                ie <= 1'b0;
            else if (ie_set)
                ie <= 1'b1;
        end
    end

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  elig,
    input  logic             ack_in,
    output logic             req_valid,
    output logic [VEC_W-1:0] req_vec,
    output logic             req_ext,
    output logic [NSRC-1:0]  take,
    output logic [NSRC-1:0]  src_ack
);

    logic [NSRC-1:0] win;

    assign win       = pick_first(elig);
    assign req_valid = |elig;
    assign req_ext   = win[SRC_EXT];
    assign take      = (ack_in && req_valid) ? win : '0;

    always_comb begin
        req_vec = '0;
        for (int i = 0; i < NSRC; i++)
            if (win[i]) req_vec = req_vec | vec_of(i);
    end

    always_ff @(posedge clk) begin
        if (rst) src_ack <= '0;
        else     src_ack <= take;
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        trap_in,
    input  logic        r75_in,
    input  logic        r65_in,
    input  logic        r55_in,
    input  logic        ext_in,
    input  logic        ie_set,
    input  logic        ie_clr,
    input  logic        mask_wr,
    input  logic [4:0]  mask_wdata,
    output logic [7:0]  stat_rdata,
    input  logic        ack_in,
    output logic        req_valid,
    output logic [15:0] req_vec,
    output logic        req_ext,
    output logic [4:0]  src_ack
);

    logic            trap_pend, r75_pend, ext_q, ie, clr75;
    logic [NLVL-1:0] lvl_pend;
    logic [2:0]      mask;
    logic [NSRC-1:0] elig, take;
    stat_t           stat;

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= ext_in;
    end

    irqc_capture #(.N_LVL(NLVL)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .trap_in    (trap_in),
        .r75_in     (r75_in),
        .lvl_in     ({r65_in, r55_in}),
        .trap_take  (take[SRC_TRAP]),
        .r75_take   (take[SRC_R75]),
        .r75_sw_clr (clr75),
        .trap_pend  (trap_pend),
        .r75_pend   (r75_pend),
        .lvl_pend   (lvl_pend)
    );

    irqc_maskreg u_msk (
        .clk        (clk),
        .rst        (rst),
        .wr         (mask_wr),
        .wdata      (setm_t'(mask_wdata)),
        .ie_set     (ie_set),
        .ie_clr     (ie_clr),
        .take_gated (|take[NSRC-1:1]),
        .mask       (mask),
        .ie         (ie),
        .clr75      (clr75)
    );

    always_comb begin
        elig           = '0;
        elig[SRC_TRAP] = trap_pend;
        elig[SRC_R75]  = r75_pend    && !mask[2] && ie;
        elig[SRC_R65]  = lvl_pend[1] && !mask[1] && ie;
        elig[SRC_R55]  = lvl_pend[0] && !mask[0] && ie;
        elig[SRC_EXT]  = ext_q && ie;
    end

    irqc_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .ack_in    (ack_in),
        .req_valid (req_valid),
        .req_vec   (req_vec),
        .req_ext   (req_ext),
        .take      (take),
        .src_ack   (src_ack)
    );

    always_comb begin
        stat.zero = 1'b0;
        stat.pend = {r75_pend, lvl_pend[1], lvl_pend[0]};
        stat.ie   = ie;
        stat.mask = mask;
    end
    assign stat_rdata = stat;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic        clk,
    input logic        rst,
    input logic        ack_in,
    input logic        req_valid,
    input logic [15:0] req_vec,
    input logic        req_ext,
    input logic [4:0]  src_ack,
    input logic        mask_wr,
    input logic [4:0]  mask_wdata,
    input logic [7:0]  stat_rdata,
    input logic        trap_pend
);

    // R9
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_ack));

    // R9
    ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_in && req_valid) |=> (src_ack != 5'd0));

    // R2
    trap_wins_chk: assert property (@(posedge clk) disable iff (rst)
        trap_pend |-> (req_valid && req_vec == 16'h0024));

    // R8
    ext_vec_chk: assert property (@(posedge clk) disable iff (rst)
        req_ext |-> (req_valid && req_vec == 16'h0000));

    // R10
    ie_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_in && req_valid && req_vec != 16'h0024) |=> !stat_rdata[3]);

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && !mask_wdata[3]) |=> $stable(stat_rdata[2:0]));

endmodule

bind irqc_top irqc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack_in     (ack_in),
    .req_valid  (req_valid),
    .req_vec    (req_vec),
    .req_ext    (req_ext),
    .src_ack    (src_ack),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .stat_rdata (stat_rdata),
    .trap_pend  (trap_pend)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_in = 0, r75_in = 0, r65_in = 0, r55_in = 0, ext_in = 0;
    logic        ie_set = 0, ie_clr = 0, mask_wr = 0, ack_in = 0;
    logic [4:0]  mask_wdata = '0;
    logic [7:0]  stat_rdata;
    logic        req_valid, req_ext;
    logic [15:0] req_vec;
    logic [4:0]  src_ack;

    int total = 0;
    int bad   = 0;
    logic [4:0] exp_q[$];

    always #10 clk = ~clk;

    irqc_top uut (
        .clk(clk), .rst(rst), .trap_in(trap_in), .r75_in(r75_in),
        .r65_in(r65_in), .r55_in(r55_in), .ext_in(ext_in),
        .ie_set(ie_set), .ie_clr(ie_clr), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .stat_rdata(stat_rdata), .ack_in(ack_in),
        .req_valid(req_valid), .req_vec(req_vec), .req_ext(req_ext),
        .src_ack(src_ack)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic mwr(input logic [4:0] v);
        mask_wr = 1'b1; mask_wdata = v;
        tick();
        mask_wr = 1'b0;
    endtask

    task automatic en();
        ie_set = 1'b1;
        tick();
        ie_set = 1'b0;
    endtask

    task automatic see(input string tag, input logic [15:0] vec, input logic ext);
        chk(req_valid == 1'b1, {tag, " valid"}, 32'(req_valid), 32'd1);
        chk(req_vec == vec, {tag, " vector"}, 32'(req_vec), 32'(vec));
        chk(req_ext == ext, {tag, " ext flag"}, 32'(req_ext), 32'(ext));
    endtask

    // driver: expected acknowledge goes into the scoreboard
    task automatic service(input logic [4:0] exp_ack);
        exp_q.push_back(exp_ack);
        ack_in = 1'b1;
        tick();
        ack_in = 1'b0;
        tick();
        chk(src_ack == 5'd0, "R9 pulse width", 32'(src_ack), 32'd0);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && src_ack != 5'd0) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R9 unexpected ack actual=%h expected=00", src_ack);
            end else begin
                logic [4:0] e;
                e = exp_q.pop_front();
                chk(src_ack == e, "R9 ack bit", 32'(src_ack), 32'(e));
            end
        end
    end

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        chk(stat_rdata == 8'h07, "R1 status", 32'(stat_rdata), 32'h07);
        chk(req_valid == 1'b0, "R1 no request", 32'(req_valid), 32'd0);
        chk(src_ack == 5'd0, "R1 no ack", 32'(src_ack), 32'd0);

        // R5: no mask enable, no change
        mwr(5'h00);
        chk(stat_rdata == 8'h07, "R5 ignored write", 32'(stat_rdata), 32'h07);
        mwr(5'h08);
        chk(stat_rdata == 8'h00, "R5 R6 masks cleared", 32'(stat_rdata), 32'h00);
        en();
        chk(stat_rdata == 8'h08, "R10 R6 enable bit", 32'(stat_rdata), 32'h08);

        // R4 level 5.5
        r55_in = 1'b1;
        tick();
        chk(stat_rdata == 8'h18, "R4 R6 pending 5.5", 32'(stat_rdata), 32'h18);
        see("R7 5.5", 16'h002C, 1'b0);
        service(5'b01000);
        chk(stat_rdata == 8'h10, "R10 enable cleared", 32'(stat_rdata), 32'h10);
        chk(req_valid == 1'b0, "R10 blocked after take", 32'(req_valid), 32'd0);

        // R7 priority with several lines
        r65_in = 1'b1; ext_in = 1'b1;
        tick();
        en();
        see("R7 6.5 over 5.5 and ext", 16'h0034, 1'b0);
        service(5'b00100);
        r65_in = 1'b0;
        en();
        see("R7 5.5 over ext", 16'h002C, 1'b0);
        service(5'b01000);
        r55_in = 1'b0;
        en();
        mwr(5'h0F);
        // R8 ext ignores masks
        see("R8 ext", 16'h0000, 1'b1);
        service(5'b10000);
        ext_in = 1'b0;
        tick();

        // R3 edge latch while masked and disabled
        r75_in = 1'b1;
        tick();
        r75_in = 1'b0;
        tick();
        chk(stat_rdata == 8'h47, "R3 latched", 32'(stat_rdata), 32'h47);
        chk(req_valid == 1'b0, "R3 masked", 32'(req_valid), 32'd0);
        mwr(5'h08);
        en();
        see("R3 R7 7.5", 16'h003C, 1'b0);
        service(5'b00010);
        chk(stat_rdata == 8'h00, "R3 cleared by service", 32'(stat_rdata), 32'h00);

        // R3 software clear, masks untouched
        r75_in = 1'b1;
        tick();
        r75_in = 1'b0;
        chk(stat_rdata == 8'h40, "R3 latched again", 32'(stat_rdata), 32'h40);
        mwr(5'h10);
        chk(stat_rdata == 8'h00, "R3 write clear", 32'(stat_rdata), 32'h00);

        // R5 mask blocks a level line
        r65_in = 1'b1;
        en();
        mwr(5'h0A);
        chk(stat_rdata == 8'h2A, "R5 status", 32'(stat_rdata), 32'h2A);
        chk(req_valid == 1'b0, "R5 6.5 masked", 32'(req_valid), 32'd0);
        r65_in = 1'b0;
        mwr(5'h0F);
        tick();
        chk(stat_rdata == 8'h0F, "R6 all masked enabled", 32'(stat_rdata), 32'h0F);

        // R2 one-cycle trap blip is rejected
        trap_in = 1'b1;
        tick();
        trap_in = 1'b0;
        tick(); tick();
        chk(req_valid == 1'b0, "R2 blip rejected", 32'(req_valid), 32'd0);
        // R2 sustained trap
        trap_in = 1'b1;
        tick();
        chk(req_valid == 1'b0, "R2 not yet", 32'(req_valid), 32'd0);
        tick();
        see("R2 trap", 16'h0024, 1'b0);
        service(5'b00001);
        chk(stat_rdata == 8'h0F, "R2 enable kept", 32'(stat_rdata), 32'h0F);
        tick();
        chk(req_valid == 1'b0, "R2 no retrigger", 32'(req_valid), 32'd0);
        trap_in = 1'b0;

        // R10 disable command
        ie_clr = 1'b1;
        tick();
        ie_clr = 1'b0;
        chk(stat_rdata == 8'h07, "R10 clear command", 32'(stat_rdata), 32'h07);

        tick();
        chk(exp_q.size() == 0, "R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule